// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block drives an external analog-to-digital converter one conversion at a time. A configuration write gives a 2-bit mode, a channel number and a start request. The block turns these into a conversion request pulse and a channel number. It keeps the channel steady until the converter reports completion. Each completed result is then labelled with the channel it came from. Two kinds of operation exist. The fixed kind converts one channel once or repeatedly. The scan kind walks from the selected channel down to channel 0, once or repeatedly.

Software may rewrite the configuration at any time. While the block is busy, a write is stored but only takes effect at a boundary. A new mode is read when the current conversion ends. A new channel or start is read after the current conversion in fixed operation, and only after channel 0 in scan operation. A write that changes the mode without a start never launches anything. In single modes the start request clears itself once it is taken. In continuous modes it stays set until software writes it low.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Mode encoding is 00 fixed single, 01 fixed continuous, 10 scan single, 11 scan continuous. While idle, a write with start = 1 raises `convReq` for exactly one cycle after the write edge. In that same cycle `busy` = 1 and `convChan` equals the written channel.
- R2: In fixed single mode, one completion ends the run: `busy` returns to 0 and no further request follows, because start has cleared itself.
- R3: In fixed continuous mode, each completion re-requests the same channel while start stays 1. After start is written 0, the run stops at the end of the conversion in progress.
- R4: In scan single mode from channel c, the channels c, c-1, ..., 0 are requested in that order, one new request per completion. The block then goes idle.
- R5: In scan continuous mode, the completion of channel 0 restarts the scan at the selected channel while start is 1. If start has been written 0, the current sequence still runs to channel 0 and the block then stops.
- R6: `busy` is 0 after reset and while idle. It is 1 from the request cycle until the completion that ends the run. `convReq` is never 1 while `busy` is 0.
- R7: One cycle after each completion seen while busy, `resultValid` pulses for one cycle. At the same time `resultChan` shows the channel that was converted, and it holds that value until the next result.
- R8: A mode written during a conversion takes effect when that conversion completes. Switching to a scan mode during a fixed conversion of channel n makes the block convert n-1 down to 0 next.
- R9: During a fixed conversion, a written channel or start is used at the next completion. During a scan, a written channel or start is used only after channel 0 completes. `convChan` never changes while a conversion is in progress.
- R10: While idle, a write that selects a scan mode with start = 0 launches no conversion.
- R11: A completion signal while idle has no effect on `busy`, `convReq` or the result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgMode | input | 2 | Mode written with the strobe |
| cfgChan | input | CHAN_W | Channel written with the strobe |
| cfgStart | input | 1 | Start request written with the strobe |
| convDone | input | 1 | Converter completion pulse |
| convReq | output | 1 | One-cycle conversion request |
| convChan | output | CHAN_W | Channel to convert |
| busy | output | 1 | Conversion or sequence in progress |
| resultValid | output | 1 | One-cycle result tag strobe |
| resultChan | output | CHAN_W | Channel of the latest completed conversion |

## Verification
The bench builds the block with CHAN_W = 4, which gives 16 channels. This lets a scan start as high as channel 9 and walk all the way down to 0 within a few dozen cycles. With this width the bench can reach the deferral corners directly. It covers a channel rewritten mid-scan that must wait for channel 0, and a fixed-to-scan switch that continues from n-1. It also covers a continuous scan that is stopped in the middle of a sequence.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    MODE_FIX_ONE  = 2'b00,
    MODE_FIX_RUN  = 2'b01,
    MODE_SCAN_ONE = 2'b10,
    MODE_SCAN_RUN = 2'b11
  } scanModeE;

  typedef struct packed {
    logic launch;    // load channel from configuration and request
    logic stepDown;  // next scan channel, request
    logic consume;   // clear the stored start request
    logic tag;       // capture result channel
  } seqStrobeT;
endpackage

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  scanModeE          wrMode,
  input  logic [CHAN_W-1:0] wrChan,
  input  logic              wrStart,
  input  seqStrobeT         stb,
  output scanModeE          effMode,
  output logic              effStart,
  output logic              atZero,
  output logic [CHAN_W-1:0] convChan,
  output logic              resultValid,
  output logic [CHAN_W-1:0] resultChan
);
  localparam logic [CHAN_W-1:0] CHAN_ZERO = '0;

  scanModeE          modeQ;
  logic [CHAN_W-1:0] chanQ;
  logic              startQ;
  logic [CHAN_W-1:0] curChan;
  logic [CHAN_W-1:0] effChan;

  // A write in the same cycle as a boundary is seen at that boundary
  assign effMode  = cfgWr ? wrMode  : modeQ;
  assign effChan  = cfgWr ? wrChan  : chanQ;
  assign effStart = cfgWr ? wrStart : startQ;
  assign atZero   = (curChan == CHAN_ZERO);
  assign convChan = curChan;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_FIX_ONE;
      chanQ  <= '0;
      startQ <= 1'b0;
    end else begin
      if (cfgWr) begin
        modeQ <= wrMode;
        chanQ <= wrChan;
      end
      if (stb.consume)   startQ <= 1'b0;
      else if (cfgWr)    startQ <= wrStart;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curChan <= '0;
    end else if (stb.launch) begin
      curChan <= effChan;
    end else if (stb.stepDown) begin
      curChan <= curChan - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      resultChan  <= '0;
    end else begin
      resultValid <= stb.tag;
      if (stb.tag) resultChan <= curChan;
    end
  end

  // R4: a scan step requests the next lower channel
  assert_scan_descends_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepDown |=> (convChan == $past(convChan) - 1'b1));

  // R7: the tag carries the channel that was just converted
  assert_tag_matches_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.tag |=> (resultValid && resultChan == $past(convChan)));
endmodule

// File: rtl/adc_seq_control.sv
module adc_seq_control
  import adc_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWr,
  input  logic      wrStart,
  input  logic      convDone,
  input  scanModeE  effMode,
  input  logic      effStart,
  input  logic      atZero,
  output seqStrobeT stb,
  output logic      busy,
  output logic      convReq
);
  logic busyQ;
  logic reqQ;
  logic boundary;
  logic scanMore;
  logic idleLaunch;
  logic edgeLaunch;

  assign boundary   = busyQ && convDone;
  // The freshly applied mode decides whether the walk continues downward
  assign scanMore   = boundary && effMode[1] && !atZero;
  assign idleLaunch = !busyQ && cfgWr && wrStart;
  assign edgeLaunch = boundary && !scanMore && effStart;

  always_comb begin
    stb          = '0;
    stb.launch   = idleLaunch || edgeLaunch;
    stb.stepDown = scanMore;
    stb.consume  = (idleLaunch || edgeLaunch) && !effMode[0];
    stb.tag      = boundary;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      reqQ  <= 1'b0;
    end else begin
      reqQ <= stb.launch || scanMore;
      if (stb.launch || scanMore) busyQ <= 1'b1;
      else if (boundary)          busyQ <= 1'b0;
    end
  end

  assign busy    = busyQ;
  assign convReq = reqQ;

  // R10: an idle write without start leaves the block idle
  assert_no_silent_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && cfgWr && !wrStart) |=> (!busy && !convReq));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [1:0]        cfgMode,
  input  logic [CHAN_W-1:0] cfgChan,
  input  logic              cfgStart,
  input  logic              convDone,
  output logic              convReq,
  output logic [CHAN_W-1:0] convChan,
  output logic              busy,
  output logic              resultValid,
  output logic [CHAN_W-1:0] resultChan
);
  seqStrobeT stb;
  scanModeE  effMode;
  logic      effStart;
  logic      atZero;

  adc_seq_datapath #(.CHAN_W(CHAN_W)) u_path (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .wrMode(scanModeE'(cfgMode)),
    .wrChan(cfgChan), .wrStart(cfgStart), .stb(stb), .effMode(effMode),
    .effStart(effStart), .atZero(atZero), .convChan(convChan),
    .resultValid(resultValid), .resultChan(resultChan)
  );

  adc_seq_control u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .wrStart(cfgStart),
    .convDone(convDone), .effMode(effMode), .effStart(effStart),
    .atZero(atZero), .stb(stb), .busy(busy), .convReq(convReq)
  );

  // R6: no request while idle
  assert_req_while_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> busy);

  // R9: the channel under conversion is held until completion
  assert_chan_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !convDone) |=> $stable(convChan));
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;
  localparam int NVEC = 17;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWr = 1'b0;
  logic [1:0]    cfgMode = 2'b00;
  logic [CW-1:0] cfgChan = '0;
  logic          cfgStart = 1'b0;
  logic          convDone = 1'b0;
  logic          convReq;
  logic [CW-1:0] convChan;
  logic          busy;
  logic          resultValid;
  logic [CW-1:0] resultChan;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  adc_seq_ctrl #(.CHAN_W(CW)) uut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgMode(cfgMode),
    .cfgChan(cfgChan), .cfgStart(cfgStart), .convDone(convDone),
    .convReq(convReq), .convChan(convChan), .busy(busy),
    .resultValid(resultValid), .resultChan(resultChan)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Row: {wr, mode, chan, start, done, | req, convChan, busy, rv, resultChan}
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1,2'd0,4'd5,1'b1,1'b0, 1'b1,4'd5,1'b1,1'b0,4'd0}, // R1 fixed single launch
    {1'b0,2'd0,4'd0,1'b0,1'b0, 1'b0,4'd5,1'b1,1'b0,4'd0}, // R6 busy held
    {1'b0,2'd0,4'd0,1'b0,1'b1, 1'b0,4'd5,1'b0,1'b1,4'd5}, // R2 R7 single ends
    {1'b0,2'd0,4'd0,1'b0,1'b0, 1'b0,4'd5,1'b0,1'b0,4'd5}, // R2 no repeat
    {1'b1,2'd2,4'd2,1'b0,1'b0, 1'b0,4'd5,1'b0,1'b0,4'd5}, // R10 scan w/o start
    {1'b0,2'd0,4'd0,1'b0,1'b1, 1'b0,4'd5,1'b0,1'b0,4'd5}, // R11 idle done
    {1'b1,2'd2,4'd2,1'b1,1'b0, 1'b1,4'd2,1'b1,1'b0,4'd5}, // R4 scan single
    {1'b0,2'd0,4'd0,1'b0,1'b1, 1'b1,4'd1,1'b1,1'b1,4'd2}, // R4
    {1'b0,2'd0,4'd0,1'b0,1'b1, 1'b1,4'd0,1'b1,1'b1,4'd1}, // R4
    {1'b0,2'd0,4'd0,1'b0,1'b1, 1'b0,4'd0,1'b0,1'b1,4'd0}, // R4 ends idle
    {1'b0,2'd0,4'd0,1'b0,1'b0, 1'b0,4'd0,1'b0,1'b0,4'd0}, // R6 idle
    {1'b1,2'd3,4'd1,1'b1,1'b0, 1'b1,4'd1,1'b1,1'b0,4'd0}, // R5 scan continuous
    {1'b0,2'd0,4'd0,1'b0,1'b1, 1'b1,4'd0,1'b1,1'b1,4'd1}, // R5
    {1'b0,2'd0,4'd0,1'b0,1'b1, 1'b1,4'd1,1'b1,1'b1,4'd0}, // R5 restart
    {1'b1,2'd3,4'd1,1'b0,1'b0, 1'b0,4'd1,1'b1,1'b0,4'd0}, // R5 stop request
    {1'b0,2'd0,4'd0,1'b0,1'b1, 1'b1,4'd0,1'b1,1'b1,4'd1}, // R5 finishes seq
    {1'b0,2'd0,4'd0,1'b0,1'b1, 1'b0,4'd0,1'b0,1'b1,4'd0}  // R5 stops
  };

  task automatic step(input logic w, input logic [1:0] m, input logic [CW-1:0] c,
                      input logic s, input logic d);
    cfgWr = w; cfgMode = m; cfgChan = c; cfgStart = s; convDone = d;
    @(negedge clk);
  endtask

  task automatic idle1(input logic d);
    step(1'b0, 2'd0, '0, 1'b0, d);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 reset busy", busy, 0);
    chk("R6 reset convReq", convReq, 0);
    chk("R7 reset resultValid", resultValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Vector table: R1 R2 R4 R5 R6 R7 R10 R11
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][19], VEC[i][18:17], VEC[i][16:13], VEC[i][12], VEC[i][11]);
      chk($sformatf("R1/R2/R4/R5/R6/R7/R10/R11 vector %0d", i),
          {convReq, convChan, busy, resultValid, resultChan}, VEC[i][10:0]);
    end

    // R3 fixed continuous, with R9 channel rewrite during a fixed conversion
    step(1'b1, 2'd1, 4'd3, 1'b1, 1'b0);
    chk("R3 launch chan", convChan, 3);
    idle1(1'b1);
    chk("R3 rerequest", convReq, 1);
    chk("R3 same chan", convChan, 3);
    chk("R7 tag 3", resultChan, 3);
    step(1'b1, 2'd1, 4'd7, 1'b1, 1'b0);
    chk("R9 chan held mid conversion", convChan, 3);
    idle1(1'b1);
    chk("R9 new chan after fixed conv", convChan, 7);
    step(1'b1, 2'd1, 4'd7, 1'b0, 1'b0);
    chk("R3 still busy after stop write", busy, 1);
    idle1(1'b1);
    chk("R3 stopped busy", busy, 0);
    chk("R3 stopped req", convReq, 0);

    // R8 switch fixed -> scan during conversion of channel 3
    step(1'b1, 2'd0, 4'd3, 1'b1, 1'b0);
    step(1'b1, 2'd2, 4'd3, 1'b0, 1'b0);
    chk("R8 mode deferred chan", convChan, 3);
    chk("R8 mode deferred req", convReq, 0);
    idle1(1'b1);
    chk("R8 continue at n-1 req", convReq, 1);
    chk("R8 continue at n-1 chan", convChan, 2);
    idle1(1'b1);
    idle1(1'b1);
    chk("R8 reaches 0", convChan, 0);
    idle1(1'b1);
    chk("R8 ends idle", busy, 0);

    // R9 channel and start written mid-scan wait for channel 0
    step(1'b1, 2'd2, 4'd2, 1'b1, 1'b0);
    step(1'b1, 2'd2, 4'd9, 1'b1, 1'b0);
    chk("R9 scan chan held", convChan, 2);
    idle1(1'b1);
    chk("R9 scan ignores new chan", convChan, 1);
    idle1(1'b1);
    idle1(1'b1);
    chk("R9 new scan after 0 req", convReq, 1);
    chk("R9 new scan after 0 chan", convChan, 9);
    for (int k = 0; k < 9; k++) idle1(1'b1);
    chk("R4 long scan at 0", convChan, 0);
    idle1(1'b1);
    chk("R4 long scan idle", busy, 0);
    chk("R7 final tag", resultChan, 0);

    idle1(1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule